// File: doc/BRIEF.md
# Software-Started Burst Copy Engine

This block is a single-channel memory-to-memory copy engine. Software programs a source base address, a destination base address and a transfer count, then writes the control word with the enable bit and the software-request bit set. The engine reads 32-bit words through a request/acknowledge memory master port and writes them to the destination. In single mode every counted transfer is one word. In burst mode every counted transfer is a group of four words: four reads go into a local buffer, then four writes empty it.

Each address steps up or down by four bytes per word, and the source can be held at one address. Software polls a completion flag and a fault flag. Each flag is cleared by writing one to it. An interrupt output can follow these flags. The control word has fields for hardware demand mode, a channel mode code and a transfer width code. These fields are stored and read back, but they have no effect on the copy.

Top module: `sw_burst_dma`

## Requirements
- R1: Registers are decoded from the byte offset on `reg_addr`: 0x0 control, 0x4 source base, 0x8 destination base, 0xC transfer count. Offsets whose low two bits are nonzero are ignored. The three address/count registers read back what was written. After reset every register reads 0.
- R2: Control bit positions are: 0 enable, [3:2] mode code, 4 destination direction, 5 source direction, 7 source hold, 8 interrupt enable, 9 burst, [13:12] width code, 15 demand, 16 software request, 18 done, 20 fault. All other bits read 0.
- R3: Writing 1 to bit 16 starts a copy only when the same write sets bit 0 and the engine is idle. The request bit self-clears one cycle later, when the engine accepts it. A request written with bit 0 clear is ignored: the bit is not stored, no memory access occurs and no flag changes.
- R4: In single mode (bit 9 = 0) the count is the number of words. Each word is one read from the source pointer, then one write of that data to the destination pointer. A beat holds its request, address and direction until `mem_ack`.
- R5: In burst mode (bit 9 = 1) the count is the number of 16-byte groups. Each group is four reads into the buffer, then four writes of those words in the same order.
- R6: A direction bit of 0 makes its pointer step by +4 bytes per word, and a value of 1 makes it step by −4. Source hold (bit 7 = 1) keeps the source pointer at its base and overrides bit 5.
- R7: In burst mode, if the source or destination base has any of bits [3:0] set, the request sets the fault bit and makes no memory access. Single mode has no alignment rule.
- R8: A count of 0 sets the done bit at acceptance and makes no memory access.
- R9: Done (bit 18) is set when the last write is acknowledged. Writing 1 to done or fault clears that bit, and writing 0 leaves it unchanged. A set event in the same cycle as a clear wins.
- R10: `mem_err` sampled with `mem_ack` on any read or write beat ends the copy. The fault bit is set, done stays clear, `mem_req` drops in the next cycle and the failing write does not update memory.
- R11: Writing bit 0 as 0 aborts an active copy. `mem_req` is low within two cycles of that write, and neither done nor fault is set.
- R12: `irq` is high exactly while bit 8 is set and done or fault is set.
- R13: The mode code, width code and demand bit are stored and read back, but they do not change addresses, counts or data of a copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| mem_req | output | 1 | Memory beat request, held until acknowledged |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` on a read beat |
| mem_ack | input | 1 | Beat completes this cycle |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| irq | output | 1 | Stop interrupt |

## Verification
The hardest cases to reach from the ports are an abort or a bus error that lands in the middle of a burst. Both need the engine to be partway through a group with the buffer partly filled.

The bench stretches beats with a periodic acknowledge stall and counts acknowledged beats. It clears the enable bit after a known number of beats. For the error cases it plants an error response on one chosen source or destination address, which fixes the beat where the copy must stop.

The main sweep runs every combination of burst mode, both direction bits, source hold and counts of one to three. For each run it computes the expected image of the destination region arithmetically.

// File: rtl/bdma_pkg.sv
package bdma_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned OFS_W  = 4;

  localparam int unsigned CTL_RUN      = 0;
  localparam int unsigned CTL_MODE_LO  = 2;
  localparam int unsigned CTL_DST_DN   = 4;
  localparam int unsigned CTL_SRC_DN   = 5;
  localparam int unsigned CTL_SRC_HOLD = 7;
  localparam int unsigned CTL_IRQ_EN   = 8;
  localparam int unsigned CTL_QUAD     = 9;
  localparam int unsigned CTL_WIDTH_LO = 12;
  localparam int unsigned CTL_DEMAND   = 15;
  localparam int unsigned CTL_GO       = 16;
  localparam int unsigned CTL_DONE     = 18;
  localparam int unsigned CTL_FAULT    = 20;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_SRC  = 2'd1;
  localparam logic [1:0] SEL_DST  = 2'd2;
  localparam logic [1:0] SEL_CNT  = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } bdma_state_e;

  typedef struct packed {
    logic       run;
    logic [1:0] mode;
    logic       dst_dn;
    logic       src_dn;
    logic       src_hold;
    logic       irq_en;
    logic       quad;
    logic [1:0] width;
    logic       demand;
  } bdma_cfg_t;

  // Next pointer value after one word.
  function automatic logic [WORD_W-1:0] bdma_step(input logic [WORD_W-1:0] a,
                                                  input logic dn, input logic hold,
                                                  input logic [WORD_W-1:0] stride);
    if (hold) return a;
    return dn ? (a - stride) : (a + stride);
  endfunction

  // True when either base has bits inside the group alignment mask.
  function automatic logic bdma_misaligned(input logic [WORD_W-1:0] s,
                                           input logic [WORD_W-1:0] d,
                                           input logic [WORD_W-1:0] mask);
    return |((s | d) & mask);
  endfunction

  function automatic bdma_cfg_t bdma_unpack_ctrl(input logic [WORD_W-1:0] w);
    bdma_cfg_t c;
    c.run      = w[CTL_RUN];
    c.mode     = w[CTL_MODE_LO +: 2];
    c.dst_dn   = w[CTL_DST_DN];
    c.src_dn   = w[CTL_SRC_DN];
    c.src_hold = w[CTL_SRC_HOLD];
    c.irq_en   = w[CTL_IRQ_EN];
    c.quad     = w[CTL_QUAD];
    c.width    = w[CTL_WIDTH_LO +: 2];
    c.demand   = w[CTL_DEMAND];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] bdma_pack_ctrl(input bdma_cfg_t c, input logic go,
                                                       input logic done, input logic fault);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CTL_RUN]            = c.run;
    w[CTL_MODE_LO +: 2]   = c.mode;
    w[CTL_DST_DN]         = c.dst_dn;
    w[CTL_SRC_DN]         = c.src_dn;
    w[CTL_SRC_HOLD]       = c.src_hold;
    w[CTL_IRQ_EN]         = c.irq_en;
    w[CTL_QUAD]           = c.quad;
    w[CTL_WIDTH_LO +: 2]  = c.width;
    w[CTL_DEMAND]         = c.demand;
    w[CTL_GO]             = go;
    w[CTL_DONE]           = done;
    w[CTL_FAULT]          = fault;
    return w;
  endfunction

endpackage

// File: rtl/bdma_regs.sv
module bdma_regs
  import bdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              eng_busy,
  input  logic              eng_accept,
  input  logic              eng_set_done,
  input  logic              eng_set_fault,
  output bdma_cfg_t         cfg,
  output logic [WORD_W-1:0] src_base,
  output logic [WORD_W-1:0] dst_base,
  output logic [WORD_W-1:0] xfer_cnt,
  output logic              go_pend,
  output logic              irq
);

  logic       word_ok;
  logic [1:0] sel;
  logic       wr_ok;
  logic       wr_ctrl;
  logic       go_ok;
  logic       done_q;
  logic       fault_q;

  assign word_ok = (reg_addr[1:0] == 2'b00);
  assign sel     = reg_addr[3:2];
  assign wr_ok   = reg_wr && word_ok;
  assign wr_ctrl = wr_ok && (sel == SEL_CTRL);
  assign go_ok   = wr_ctrl && reg_wdata[CTL_GO] && reg_wdata[CTL_RUN] && !eng_busy && !go_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      src_base <= '0;
      dst_base <= '0;
      xfer_cnt <= '0;
      go_pend  <= 1'b0;
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      if (wr_ctrl) cfg <= bdma_unpack_ctrl(reg_wdata);
      if (wr_ok && sel == SEL_SRC) src_base <= reg_wdata;
      if (wr_ok && sel == SEL_DST) dst_base <= reg_wdata;
      if (wr_ok && sel == SEL_CNT) xfer_cnt <= reg_wdata;

      if (go_ok)                        go_pend <= 1'b1;
      else if (eng_accept || !cfg.run)  go_pend <= 1'b0;

      if (eng_set_done)                          done_q <= 1'b1;
      else if (wr_ctrl && reg_wdata[CTL_DONE])   done_q <= 1'b0;

      if (eng_set_fault)                         fault_q <= 1'b1;
      else if (wr_ctrl && reg_wdata[CTL_FAULT])  fault_q <= 1'b0;
    end
  end

  assign irq = cfg.irq_en && (done_q || fault_q);

  always_comb begin
    reg_rdata = '0;
    if (word_ok) begin
      unique case (sel)
        SEL_CTRL: reg_rdata = bdma_pack_ctrl(cfg, go_pend, done_q, fault_q);
        SEL_SRC:  reg_rdata = src_base;
        SEL_DST:  reg_rdata = dst_base;
        default:  reg_rdata = xfer_cnt;
      endcase
    end
  end

  AST_GO_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    go_pend |=> !go_pend); // R3
  AST_DONE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    eng_set_done |=> done_q); // R9
  AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_q) |-> $past(wr_ctrl && reg_wdata[CTL_DONE])); // R9
  AST_FAULT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_q) |-> $past(wr_ctrl && reg_wdata[CTL_FAULT])); // R9
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_set_fault && cfg.irq_en && !wr_ctrl) |=> irq); // R12

endmodule

// File: rtl/bdma_beat_buf.sv
module bdma_beat_buf #(
  parameter int unsigned BEATS = 4,
  parameter int unsigned W     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     idx,
  input  logic [W-1:0]         wr_data,
  output logic [W-1:0]         rd_data
);
  localparam int unsigned IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [W-1:0] slot [BEATS];

  for (genvar g = 0; g < BEATS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            slot[g] <= '0;
      else if (wr_en && idx == IDX_W'(g))    slot[g] <= wr_data;
    end
  end

  assign rd_data = slot[idx];

endmodule

// File: rtl/bdma_engine.sv
module bdma_engine
  import bdma_pkg::*;
#(
  parameter int unsigned BEATS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              src_dn,
  input  logic              dst_dn,
  input  logic              src_hold,
  input  logic              quad,
  input  logic [WORD_W-1:0] src_base,
  input  logic [WORD_W-1:0] dst_base,
  input  logic [WORD_W-1:0] xfer_cnt,
  input  logic              go_pend,
  output logic              accept,
  output logic              busy,
  output logic              set_done,
  output logic              set_fault,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err
);
  localparam int unsigned       IDX_W      = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [IDX_W-1:0]  LAST_IDX   = IDX_W'(BEATS - 1);
  localparam logic [WORD_W-1:0] STRIDE     = WORD_W'(WORD_W / 8);
  localparam logic [WORD_W-1:0] ALIGN_MASK = WORD_W'(BEATS * (WORD_W / 8) - 1);

  bdma_state_e       state;
  logic [WORD_W-1:0] src_ptr, dst_ptr, grp_left;
  logic [IDX_W-1:0]  beat_idx;
  logic              src_dn_q, dst_dn_q, hold_q, quad_q;

  logic bad_align, zero_cnt, fire, rd_fire, wr_fire, last_beat, final_grp;

  assign bad_align = quad && bdma_misaligned(src_base, dst_base, ALIGN_MASK);
  assign zero_cnt  = (xfer_cnt == '0);
  assign busy      = (state != ST_IDLE);
  assign accept    = go_pend && run && !busy;
  assign mem_req   = busy;
  assign mem_we    = (state == ST_WRITE);
  assign mem_addr  = mem_we ? dst_ptr : src_ptr;
  assign fire      = mem_req && mem_ack;
  assign rd_fire   = fire && !mem_we;
  assign wr_fire   = fire && mem_we;
  assign last_beat = quad_q ? (beat_idx == LAST_IDX) : (beat_idx == '0);
  assign final_grp = (grp_left == WORD_W'(1));

  assign set_fault = (accept && bad_align) || (run && fire && mem_err);
  assign set_done  = (accept && !bad_align && zero_cnt) ||
                     (run && wr_fire && !mem_err && last_beat && final_grp);

  bdma_beat_buf #(.BEATS(BEATS), .W(WORD_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rd_fire && !mem_err),
    .idx     (beat_idx),
    .wr_data (mem_rdata),
    .rd_data (mem_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      src_ptr  <= '0;
      dst_ptr  <= '0;
      grp_left <= '0;
      beat_idx <= '0;
      src_dn_q <= 1'b0;
      dst_dn_q <= 1'b0;
      hold_q   <= 1'b0;
      quad_q   <= 1'b0;
    end else if (!run) begin
      state    <= ST_IDLE;
      beat_idx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept && !bad_align && !zero_cnt) begin
            src_ptr  <= src_base;
            dst_ptr  <= dst_base;
            grp_left <= xfer_cnt;
            beat_idx <= '0;
            src_dn_q <= src_dn;
            dst_dn_q <= dst_dn;
            hold_q   <= src_hold;
            quad_q   <= quad;
            state    <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ack) begin
            if (mem_err) begin
              state    <= ST_IDLE;
              beat_idx <= '0;
            end else begin
              src_ptr <= bdma_step(src_ptr, src_dn_q, hold_q, STRIDE);
              if (last_beat) begin
                beat_idx <= '0;
                state    <= ST_WRITE;
              end else begin
                beat_idx <= beat_idx + 1'b1;
              end
            end
          end
        end
        ST_WRITE: begin
          if (mem_ack) begin
            if (mem_err) begin
              state    <= ST_IDLE;
              beat_idx <= '0;
            end else begin
              dst_ptr <= bdma_step(dst_ptr, dst_dn_q, 1'b0, STRIDE);
              if (last_beat) begin
                beat_idx <= '0;
                grp_left <= grp_left - 1'b1;
                state    <= final_grp ? ST_IDLE : ST_READ;
              end else begin
                beat_idx <= beat_idx + 1'b1;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mem_req); // R11
  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R4
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> !mem_req); // R10
  AST_ALIGN_SHORTCUT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bad_align) |=> !mem_req); // R7
  AST_ZERO_SHORTCUT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && zero_cnt) |=> !mem_req); // R8

endmodule

// File: rtl/sw_burst_dma.sv
module sw_burst_dma
  import bdma_pkg::*;
#(
  parameter int unsigned BEATS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              irq
);

  bdma_cfg_t         cfg;
  logic [WORD_W-1:0] src_base, dst_base, xfer_cnt;
  logic              go_pend, eng_accept, eng_busy, eng_set_done, eng_set_fault;

  bdma_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .eng_busy      (eng_busy),
    .eng_accept    (eng_accept),
    .eng_set_done  (eng_set_done),
    .eng_set_fault (eng_set_fault),
    .cfg           (cfg),
    .src_base      (src_base),
    .dst_base      (dst_base),
    .xfer_cnt      (xfer_cnt),
    .go_pend       (go_pend),
    .irq           (irq)
  );

  bdma_engine #(.BEATS(BEATS)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (cfg.run),
    .src_dn    (cfg.src_dn),
    .dst_dn    (cfg.dst_dn),
    .src_hold  (cfg.src_hold),
    .quad      (cfg.quad),
    .src_base  (src_base),
    .dst_base  (dst_base),
    .xfer_cnt  (xfer_cnt),
    .go_pend   (go_pend),
    .accept    (eng_accept),
    .busy      (eng_busy),
    .set_done  (eng_set_done),
    .set_fault (eng_set_fault),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err)
  );

endmodule

// File: tb/sw_burst_dma_tb.sv
`timescale 1ns/1ps
module sw_burst_dma_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int tests = 0;
  int fails = 0;

  logic [31:0] mem [256];
  int          beats = 0;
  logic        init_req = 1'b0;
  logic        stall = 1'b0;
  logic        ack_gate = 1'b1;
  int          cyc = 0;
  logic        err_on = 1'b0;
  logic [31:0] err_addr = '0;

  always #2.5 clk = ~clk;

  sw_burst_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq)
  );

  function automatic logic [31:0] pat(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {8'hC3, b, b ^ 8'h5A, 8'(i * 7)};
  endfunction

  assign mem_ack   = mem_req && ack_gate;
  assign mem_err   = mem_ack && err_on && (mem_addr == err_addr);
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(negedge clk) begin
    cyc      <= cyc + 1;
    ack_gate <= !stall || (cyc % 3 != 0);
  end

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
      beats <= 0;
    end else if (mem_req && mem_ack) begin
      beats <= beats + 1;
      if (mem_we && !mem_err) mem[mem_addr[9:2]] <= mem_wdata;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic init_mem();
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
  endtask

  task automatic wait_end(output logic [31:0] c);
    c = '0;
    for (int i = 0; i < 2000; i++) begin
      rd(4'h0, c);
      if (c[18] || c[20]) break;
    end
  endtask

  task automatic run_copy(input bit quad, input bit sdn, input bit ddn, input bit hold, input int cnt);
    logic [31:0] c, src, dst, ctl, extra;
    int n, s0, d0, bad;
    string tg;
    src   = sdn ? 32'h1C0 : 32'h040;
    dst   = ddn ? 32'h3C0 : 32'h240;
    n     = quad ? cnt * 4 : cnt;
    extra = (cnt == 3) ? (32'h8000 | 32'h4) : 32'h2000;
    tg = $sformatf("%s R6 R13 q%0d s%0d d%0d h%0d n%0d", quad ? "R5" : "R4", quad, sdn, ddn, hold, cnt);
    stall = (cnt == 2);
    init_mem();
    wr(4'h4, src); wr(4'h8, dst); wr(4'hC, cnt);
    ctl = 32'h1 | 32'h10000 | (32'(ddn) << 4) | (32'(sdn) << 5) | (32'(hold) << 7) | (32'(quad) << 9) | extra;
    wr(4'h0, ctl);
    wait_end(c);
    check({tg, " R9 flags"}, c & 32'h0014_0000, 32'h0004_0000);
    check({tg, " beats"}, beats, 2 * n);
    s0 = int'(src >> 2); d0 = int'(dst >> 2); bad = 0;
    for (int k = 0; k < n; k++) begin
      int si, di;
      si = hold ? s0 : (sdn ? s0 - k : s0 + k);
      di = ddn ? d0 - k : d0 + k;
      if (mem[di] !== pat(si)) bad++;
    end
    check({tg, " data"}, bad, 0);
    begin
      int di;
      di = ddn ? d0 - n : d0 + n;
      check({tg, " past end"}, mem[di], pat(di));
    end
    stall = 1'b0;
    wr(4'h0, 32'h0014_0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual=0x%08h expected=0x%08h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] c;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    init_mem();

    // R1: reset values
    rd(4'h0, c); check("R1 ctrl reset", c, 32'h0);
    rd(4'hC, c); check("R1 count reset", c, 32'h0);
    check("R1 idle port", {30'd0, mem_req, irq}, 32'h0);

    // R2 reserved bits read zero; R1 readback
    wr(4'h0, 32'hFFFE_FFFE); rd(4'h0, c); check("R2 ctrl fields", c, 32'h0000_B3BC);
    wr(4'h4, 32'h1234_5670); rd(4'h4, c); check("R1 src readback", c, 32'h1234_5670);
    wr(4'h8, 32'hCAFE_0010); rd(4'h8, c); check("R1 dst readback", c, 32'hCAFE_0010);
    wr(4'hD, 32'h0000_0055); rd(4'hC, c); check("R1 unaligned offset ignored", c, 32'h0);
    wr(4'h0, 32'h0);

    // R3: request without enable ignored
    init_mem();
    wr(4'h4, 32'h40); wr(4'h8, 32'h240); wr(4'hC, 32'd2);
    wr(4'h0, 32'h0001_0200);
    repeat (30) @(negedge clk);
    rd(4'h0, c); check("R3 request dropped without enable", c, 32'h0000_0200);
    check("R3 no access without enable", beats, 0);
    wr(4'h0, 32'h0);

    // R8: zero count, R3 self-clear
    wr(4'hC, 32'd0);
    wr(4'h0, 32'h0001_0001);
    repeat (3) @(negedge clk);
    rd(4'h0, c); check("R8 R3 zero count done", c, 32'h0004_0001);
    check("R8 no access", beats, 0);

    // R9: write-one-to-clear
    wr(4'h0, 32'h1); rd(4'h0, c); check("R9 write 0 keeps done", c, 32'h0004_0001);
    wr(4'h0, 32'h0004_0001); rd(4'h0, c); check("R9 write 1 clears done", c, 32'h1);

    // R12: interrupt
    wr(4'h0, 32'h0001_0101); repeat (3) @(negedge clk);
    check("R12 irq on done", irq, 1'b1);
    wr(4'h0, 32'h0004_0101); #1;
    check("R12 irq off after clear", irq, 1'b0);
    wr(4'h0, 32'h0001_0001); repeat (3) @(negedge clk);
    rd(4'h0, c);
    check("R12 irq masked", {c[18], irq}, 2'b10);
    wr(4'h0, 32'h0004_0000);

    // R7: misaligned burst
    init_mem();
    wr(4'h4, 32'h44); wr(4'h8, 32'h240); wr(4'hC, 32'd1);
    wr(4'h0, 32'h0001_0201); repeat (3) @(negedge clk);
    rd(4'h0, c); check("R7 src misaligned faults", c, 32'h0010_0201);
    wr(4'h0, 32'h0010_0000);
    wr(4'h4, 32'h40); wr(4'h8, 32'h248);
    wr(4'h0, 32'h0001_0201); repeat (3) @(negedge clk);
    rd(4'h0, c); check("R7 dst misaligned faults", c, 32'h0010_0201);
    check("R7 no access", beats, 0);
    wr(4'h0, 32'h0010_0000);
    wr(4'h4, 32'h44); wr(4'hC, 32'd2);
    wr(4'h0, 32'h0001_0001); wait_end(c);
    check("R7 single mode unaligned ok", c, 32'h0004_0001);
    check("R7 single data", mem[147], pat(18));
    wr(4'h0, 32'h0014_0000);

    // R10: bus error on a read beat
    init_mem();
    err_on = 1'b1; err_addr = 32'h48;
    wr(4'h4, 32'h40); wr(4'h8, 32'h240); wr(4'hC, 32'd4);
    wr(4'h0, 32'h0001_0001); wait_end(c);
    check("R10 read error flags", c, 32'h0010_0001);
    check("R10 read error beats", beats, 5);
    check("R10 copied before error", mem[145], pat(17));
    check("R10 untouched after error", mem[146], pat(146));
    wr(4'h0, 32'h0010_0000);
    // R10: bus error on a write beat
    init_mem();
    err_addr = 32'h244;
    wr(4'h0, 32'h0001_0001); wait_end(c);
    check("R10 write error flags", c, 32'h0010_0001);
    check("R10 write error beats", beats, 4);
    check("R10 failed write dropped", mem[145], pat(145));
    err_on = 1'b0;
    wr(4'h0, 32'h0010_0000);

    // R11: abort mid-burst
    init_mem();
    stall = 1'b1;
    wr(4'h4, 32'h40); wr(4'h8, 32'h240); wr(4'hC, 32'd3);
    wr(4'h0, 32'h0001_0201);
    for (int i = 0; i < 200 && beats < 3; i++) @(negedge clk);
    wr(4'h0, 32'h0);
    repeat (2) @(negedge clk);
    check("R11 request dropped", mem_req, 1'b0);
    begin
      int b;
      b = beats;
      repeat (20) @(negedge clk);
      check("R11 no further beats", beats, b);
    end
    rd(4'h0, c); check("R11 no flags", c, 32'h0);
    stall = 1'b0;

    // Sweep of modes, directions, hold and counts
    for (int q = 0; q < 2; q++)
      for (int s = 0; s < 2; s++)
        for (int d = 0; d < 2; d++)
          for (int h = 0; h < 2; h++)
            for (int n = 1; n <= 3; n++)
              run_copy(q[0], s[0], d[0], h[0], n);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule